// File: doc/BRIEF.md
# Tournament Branch Direction Predictor with Speculative History Queue

This block predicts the direction of conditional branches. Three component predictors each produce a guess for every branch. The first is a bimodal table of counters addressed by the branch address. The second is a two-step local predictor: a per-branch history table is read first, and the history it returns then addresses a pattern table. The third is a global predictor that addresses its pattern table with the branch address XORed with a shared history of recent outcomes. A chooser table, also addressed by the branch address, decides which of the three guesses is used. The prediction is returned one cycle after the request, together with a code that names the component that supplied it.

Predicted directions do not go straight into the history state. Each one is placed in a four-entry speculative history queue. History changes only when a prediction arrives while the queue is full. At that point the oldest entry leaves the queue and is shifted into both the local history of its own branch and the global history. A flush empties the queue and commits nothing. Resolved outcomes arrive on a separate update port. They train all three components and the chooser, and one update can be accepted every cycle alongside one prediction.

Top module: `tourn_pred`

## Requirements
- R1: A prediction request with `pred_valid` high in a cycle produces `pred_out_valid` high after the next clock edge. A cycle without a request produces `pred_out_valid` low after that edge.
- R2: `pred_src` encodes the supplying component as 0 = bimodal, 1 = local, 2 = global. After reset every counter holds 1 and every chooser entry holds 0, so any branch is predicted not-taken by the bimodal component.
- R3: Every pattern counter is 2 bits wide and predicts taken when its value is 2 or 3. An update with `upd_taken` high increments the counter and one with it low decrements it. The count stops at 3 going up and at 0 going down.
- R4: The bimodal counter and the chooser entry are addressed by PC bits [5:0]. Two addresses that agree in those bits share both entries.
- R5: The local predictor reads a 6-bit history from a 32-entry table addressed by PC bits [4:0]. That history addresses the 64-entry local pattern table.
- R6: The global pattern table has 256 entries. It is addressed by the 8-bit PC XORed with the 8-bit committed global history.
- R7: On an update, the chooser entry is left alone if the component it currently selects was correct, or if no component was correct. Otherwise it is set to the first correct component in the order bimodal, local, global.
- R8: When a prediction and an update fall in the same cycle and touch the same counter or chooser entry, the prediction sees the value after the update.
- R9: Each valid prediction pushes its predicted direction into a 4-entry queue, with taken = 1. A push onto a full queue commits the oldest entry: its bit is shifted into the LSB of its branch's local history and into the LSB of the global history. Otherwise the history state does not change.
- R10: `flush` empties the queue without committing any entry. A prediction made in the same cycle as a flush is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | 8 | Branch address to predict |
| flush | input | 1 | Discard the speculative history queue |
| upd_valid | input | 1 | Resolved outcome present |
| upd_pc | input | 8 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_out_valid | output | 1 | Registered prediction valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_src | output | 2 | Component that supplied the prediction |

## Verification
The hardest case to reach from the ports is the commit of a queued history bit. It only shows up when the committing branch's local history moves to a pattern counter that disagrees with the old one. That difference is only visible if the chooser already selects the local component for that branch. The stimulus first saturates the shared local pattern counter through a second branch. It then trains one branch so the chooser moves it to local. Finally it issues repeated predictions around a flush and checks the exact prediction at which the answer flips to not-taken. Chooser moves to the global component are reached with two addresses that share a bimodal entry but map to different global entries.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    SRC_BIM = 2'd0,
    SRC_LOC = 2'd1,
    SRC_GLB = 2'd2
  } src_e;

  localparam logic [1:0] CTR_INIT = 2'd1;

  function automatic logic [1:0] sat_step(input logic [1:0] ctr, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (ctr == 2'd3) ? 2'd3 : ctr + 2'd1;
    else    nxt = (ctr == 2'd0) ? 2'd0 : ctr - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_fwd_ram.sv
module tp_fwd_ram #(
  parameter int IDX_W = 6,
  parameter int DAT_W = 2,
  parameter int NRD = 2,
  parameter logic [DAT_W-1:0] RST_VAL = '0,
  parameter bit FWD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DAT_W-1:0] wdat,
  input  logic [IDX_W-1:0] rd_idx [NRD],
  output logic [DAT_W-1:0] rd_dat [NRD]
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (we) begin
      mem[widx] <= wdat;
    end
  end

  // Port 0 serves predictions; it may see a same-cycle write first.
  generate
    if (FWD) begin : g_fwd
      assign rd_dat[0] = (we && widx == rd_idx[0]) ? wdat : mem[rd_idx[0]];
    end else begin : g_nofwd
      assign rd_dat[0] = mem[rd_idx[0]];
    end
    for (genvar p = 1; p < NRD; p++) begin : g_rd
      assign rd_dat[p] = mem[rd_idx[p]];
    end
  endgenerate

endmodule

// File: rtl/tp_shq.sv
module tp_shq #(
  parameter int DEPTH = 4,
  parameter int DAT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DAT_W-1:0] push_dat,
  input  logic             flush,
  output logic             commit_vld,
  output logic [DAT_W-1:0] commit_dat,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DAT_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign commit_vld = push && !flush && full;
  assign commit_dat = ent_q[0];
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush && !rst) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) ent_q[i] <= ent_q[i+1];
        ent_q[DEPTH-1] <= push_dat;
      end else begin
        ent_q[cnt_q[PTR_W-1:0]] <= push_dat;
      end
    end
  end

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
  parameter int PC_W      = 8,
  parameter int BIM_W     = 6,
  parameter int META_W    = 6,
  parameter int LHT_W     = 5,
  parameter int LHIST_W   = 6,
  parameter int SHQ_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  input  logic            flush,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            pred_out_valid,
  output logic            pred_taken,
  output logic [1:0]      pred_src
);
  import tp_pkg::*;

  localparam int GHIST_W = PC_W;
  localparam int SHQ_W   = LHT_W + 1;
  localparam int CNT_W   = $clog2(SHQ_DEPTH + 1);

  // ---------------- committed global history ----------------
  logic [GHIST_W-1:0] ghist_q;
  logic               cm_vld;
  logic [SHQ_W-1:0]   cm_dat;
  logic [CNT_W-1:0]   shq_count;

  always_ff @(posedge clk) begin
    if (rst) ghist_q <= '0;
    else if (cm_vld) ghist_q <= {ghist_q[GHIST_W-2:0], cm_dat[0]};
  end

  // ---------------- table read/write wiring ----------------
  logic [BIM_W-1:0]   bim_ri [2];
  logic [1:0]         bim_rd [2];
  logic [LHIST_W-1:0] lpt_ri [2];
  logic [1:0]         lpt_rd [2];
  logic [GHIST_W-1:0] gpt_ri [2];
  logic [1:0]         gpt_rd [2];
  logic [META_W-1:0]  meta_ri [2];
  logic [1:0]         meta_rd [2];
  logic [LHT_W-1:0]   lht_ri [3];
  logic [LHIST_W-1:0] lht_rd [3];

  logic [1:0]         bim_wd, lpt_wd, gpt_wd, meta_wd;
  logic [LHIST_W-1:0] lht_wd;

  // port 0: prediction, port 1: update, lht port 2: commit
  assign bim_ri[0]  = pred_pc[BIM_W-1:0];
  assign bim_ri[1]  = upd_pc[BIM_W-1:0];
  assign meta_ri[0] = pred_pc[META_W-1:0];
  assign meta_ri[1] = upd_pc[META_W-1:0];
  assign lht_ri[0]  = pred_pc[LHT_W-1:0];
  assign lht_ri[1]  = upd_pc[LHT_W-1:0];
  assign lht_ri[2]  = cm_dat[SHQ_W-1:1];
  assign lpt_ri[0]  = lht_rd[0];
  assign lpt_ri[1]  = lht_rd[1];
  assign gpt_ri[0]  = pred_pc ^ ghist_q;
  assign gpt_ri[1]  = upd_pc ^ ghist_q;

  tp_fwd_ram #(.IDX_W(BIM_W), .DAT_W(2), .NRD(2), .RST_VAL(CTR_INIT), .FWD(1'b1)) u_bim (
    .clk(clk), .rst(rst), .we(upd_valid), .widx(bim_ri[1]), .wdat(bim_wd),
    .rd_idx(bim_ri), .rd_dat(bim_rd));

  tp_fwd_ram #(.IDX_W(LHIST_W), .DAT_W(2), .NRD(2), .RST_VAL(CTR_INIT), .FWD(1'b1)) u_lpt (
    .clk(clk), .rst(rst), .we(upd_valid), .widx(lpt_ri[1]), .wdat(lpt_wd),
    .rd_idx(lpt_ri), .rd_dat(lpt_rd));

  tp_fwd_ram #(.IDX_W(GHIST_W), .DAT_W(2), .NRD(2), .RST_VAL(CTR_INIT), .FWD(1'b1)) u_gpt (
    .clk(clk), .rst(rst), .we(upd_valid), .widx(gpt_ri[1]), .wdat(gpt_wd),
    .rd_idx(gpt_ri), .rd_dat(gpt_rd));

  tp_fwd_ram #(.IDX_W(META_W), .DAT_W(2), .NRD(2), .RST_VAL(2'd0), .FWD(1'b1)) u_meta (
    .clk(clk), .rst(rst), .we(upd_valid), .widx(meta_ri[1]), .wdat(meta_wd),
    .rd_idx(meta_ri), .rd_dat(meta_rd));

  // Local histories change only on commit; reads see the pre-commit value.
  tp_fwd_ram #(.IDX_W(LHT_W), .DAT_W(LHIST_W), .NRD(3), .RST_VAL('0), .FWD(1'b0)) u_lht (
    .clk(clk), .rst(rst), .we(cm_vld), .widx(lht_ri[2]), .wdat(lht_wd),
    .rd_idx(lht_ri), .rd_dat(lht_rd));

  assign lht_wd = {lht_rd[2][LHIST_W-2:0], cm_dat[0]};

  // ---------------- prediction path ----------------
  logic p_dir;
  src_e p_src;

  always_comb begin
    unique case (meta_rd[0])
      2'd0:    begin p_src = SRC_BIM; p_dir = bim_rd[0][1]; end
      2'd1:    begin p_src = SRC_LOC; p_dir = lpt_rd[0][1]; end
      default: begin p_src = SRC_GLB; p_dir = gpt_rd[0][1]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_out_valid <= 1'b0;
      pred_taken     <= 1'b0;
      pred_src       <= SRC_BIM;
    end else begin
      pred_out_valid <= pred_valid;
      if (pred_valid) begin
        pred_taken <= p_dir;
        pred_src   <= p_src;
      end
    end
  end

  // ---------------- update path ----------------
  logic bim_ok, loc_ok, glb_ok, sel_ok;

  assign bim_ok = (bim_rd[1][1] == upd_taken);
  assign loc_ok = (lpt_rd[1][1] == upd_taken);
  assign glb_ok = (gpt_rd[1][1] == upd_taken);

  always_comb begin
    unique case (meta_rd[1])
      2'd0:    sel_ok = bim_ok;
      2'd1:    sel_ok = loc_ok;
      default: sel_ok = glb_ok;
    endcase
    meta_wd = meta_rd[1];
    if (!sel_ok) begin
      if (bim_ok)      meta_wd = SRC_BIM;
      else if (loc_ok) meta_wd = SRC_LOC;
      else if (glb_ok) meta_wd = SRC_GLB;
    end
  end

  assign bim_wd = sat_step(bim_rd[1], upd_taken);
  assign lpt_wd = sat_step(lpt_rd[1], upd_taken);
  assign gpt_wd = sat_step(gpt_rd[1], upd_taken);

  // ---------------- speculative history queue ----------------
  tp_shq #(.DEPTH(SHQ_DEPTH), .DAT_W(SHQ_W)) u_shq (
    .clk(clk), .rst(rst), .push(pred_valid), .push_dat({lht_ri[0], p_dir}),
    .flush(flush), .commit_vld(cm_vld), .commit_dat(cm_dat), .count(shq_count));

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int SHQ_DEPTH = 4
) (
  input logic clk,
  input logic rst,
  input logic pred_valid,
  input logic flush,
  input logic pred_out_valid,
  input logic [1:0] pred_src,
  input logic [$clog2(SHQ_DEPTH+1)-1:0] shq_cnt
);

  // R1: output valid follows a request by one edge
  a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_out_valid);

  // R1: no request, no output
  a_r1_idle_next: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_out_valid);

  // R2: source code is one of the three components
  a_r2_src_legal: assert property (@(posedge clk) disable iff (rst)
    pred_out_valid |-> pred_src != 2'd3);

  // R10: flush leaves the queue empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> shq_cnt == '0);

  // R9: a push onto a non-full queue grows it by one
  a_r9_push_grows: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !flush && shq_cnt < SHQ_DEPTH) |=> shq_cnt == $past(shq_cnt) + 1'b1);

  // R9: occupancy never exceeds the queue depth
  a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
    shq_cnt <= SHQ_DEPTH);

endmodule

bind tourn_pred tp_checker #(.SHQ_DEPTH(SHQ_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pred_valid(pred_valid), .flush(flush),
  .pred_out_valid(pred_out_valid), .pred_src(pred_src), .shq_cnt(shq_count));

// File: tb/tourn_pred_test.sv
`timescale 1ns/1ps
module tourn_pred_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       pred_valid, flush, upd_valid, upd_taken;
  logic [7:0] pred_pc, upd_pc;
  logic       pred_out_valid, pred_taken;
  logic [1:0] pred_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tourn_pred uut (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .flush(flush), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken), .pred_src(pred_src));

  typedef struct packed {
    logic       pv;
    logic [7:0] ppc;
    logic       uv;
    logic [7:0] upc;
    logic       ut;
    logic       fl;
    logic       ev;
    logic       et;
    logic [1:0] es;
  } vec_t;

  localparam int NV = 15;
  // flush held high in every vector so no history is ever committed
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    '{1'b1, 8'h13, 1'b1, 8'h13, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b0, 8'h00, 1'b1, 8'h13, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b0, 8'h00, 1'b1, 8'h25, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 8'h13, 1'b1, 8'h13, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1},
    '{1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1},
    '{1'b0, 8'h00, 1'b1, 8'h32, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 8'h32, 1'b1, 8'h72, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
    '{1'b1, 8'h72, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
    '{1'b0, 8'h00, 1'b1, 8'h72, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 8'h72, 1'b1, 8'h72, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
    '{1'b1, 8'h32, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
    '{1'b1, 8'h65, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b1, 8'h26, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  function automatic string vtag(input int i);
    case (i)
      0:       return "R2 reset state";
      1:       return "R8 update before prediction";
      2:       return "R3 counter at 2 is taken";
      3, 4, 7, 10: return "R1 idle cycle";
      5:       return "R7 chooser to local";
      6:       return "R5 local prediction";
      8:       return "R7 chooser to global";
      9, 12:   return "R6 global index";
      11:      return "R3 floor at 0";
      default: return "R4 bimodal index";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic pv, input logic [7:0] ppc, input logic uv,
                      input logic [7:0] upc, input logic ut, input logic fl);
    @(negedge clk);
    pred_valid = pv; pred_pc = ppc; upd_valid = uv; upd_pc = upc;
    upd_taken = ut; flush = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pred_valid = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; flush = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic expect_pred(input string tag, input logic t, input logic [1:0] s);
    check(tag, {1'b0, pred_out_valid, pred_taken, 1'b0}, {1'b0, 1'b1, t, 1'b0});
    check(tag, {2'b00, pred_src}, {2'b00, s});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pred_valid = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; flush = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset values at the outputs
    check("R2 reset outputs", {1'b0, pred_out_valid, pred_src}, 4'b0000);
    check("R2 reset taken", {3'b000, pred_taken}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].pv, VEC[i].ppc, VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].fl);
      if (VEC[i].ev) begin
        check(vtag(i), {pred_out_valid, pred_taken, pred_src},
              {1'b1, VEC[i].et, VEC[i].es});
      end else begin
        check(vtag(i), {3'b000, pred_out_valid}, 4'b0000);
      end
    end

    // ---- R9 / R10: queue commit and flush, observed through the local path ----
    do_reset();
    step(1'b0, 8'h00, 1'b1, 8'h06, 1'b1, 1'b0);  // shared local counter -> 2
    step(1'b0, 8'h00, 1'b1, 8'h06, 1'b1, 1'b0);  // -> 3
    step(1'b0, 8'h00, 1'b1, 8'h05, 1'b1, 1'b0);  // chooser for 0x05 -> local
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0);
      expect_pred("R5 local history zero", 1'b1, 2'd1);
    end
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);    // flush, nothing committed
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0);
      expect_pred("R10 flush discards queue", 1'b1, 2'd1);
    end
    // the fifth push found the queue full and committed a taken bit
    step(1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0);
    expect_pred("R9 commit shifts local history", 1'b0, 2'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule